// File: doc/BRIEF.md
# Envelope Step Rate Prescaler

This block turns the system clock into a train of envelope step strobes. It does not use a binary counter with a compare. A 15-bit maximal-length linear feedback shift register runs freely, one shift per clock, starting from the all-ones state. A decoder compares the register with a terminal pattern. When the pattern appears, the block raises a one-cycle step strobe and loads all ones back into the register, which starts the next interval.

Three 4-bit rate codes feed the block, one each for the attack, decay and release phases. A 2-bit phase select chooses which code is in force. Each of the 16 codes maps to a fixed step period. From that period a terminal pattern is computed at elaboration time: it is the register state that the sequence reaches that many cycles minus one after leaving all ones. The envelope counter that consumes the strobe sits outside this block.

Top module: `env_rate_prescaler`

## Requirements
- R1: While `rst` is high the strobe is low and the register holds all ones. After `rst` falls, the first strobe appears exactly N clock edges later, where N is the period of the selected code.
- R2: The register shifts on every clock edge with maximal-length feedback. It never holds zero, and without a match it returns to any given state after 32767 edges.
- R3: Rate code 0 gives a period of 8 clocks.
- R4: Rate codes 0 to 15 give these periods in clocks: 8, 32, 63, 95, 149, 220, 267, 313, 392, 977, 1954, 3126, 3907, 11720, 19532, 31251.
- R5: Phase select 0 takes the attack code, 1 takes the decay code, and both 2 and 3 take the release code.
- R6: `step` is a registered strobe that is high for exactly one clock per match, in the cycle after the edge at which the match is taken.
- R7: A match reloads all ones, so under a fixed code successive strobes are exactly N clocks apart.
- R8: A change of the selected code or of the phase select acts at the next comparison and does not reload the register. If the new terminal state has already gone by in the current interval, the next strobe comes only after the sequence wraps: 32767 + N clocks after the last reload.
- R9: The rate codes of the phases that are not selected have no effect on the strobe timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_atk | input | 4 | Attack rate code |
| rate_dcy | input | 4 | Decay rate code |
| rate_rel | input | 4 | Release rate code |
| phase_sel | input | 2 | Phase select (0 attack, 1 decay, 2 or 3 release) |
| step | output | 1 | One-cycle envelope step strobe |

## Verification
Clock edges are counted from the edge at which all ones is first compared. A strobe is therefore due at the end of edge N after a reload or a reset release. The driver records the exact edge number of every expected strobe and changes inputs only at falling edges, so a change takes effect at the next rising edge. The monitor samples `step` at each falling edge and pairs every strobe with the next expected edge number. A strobe that arrives early, a strobe that arrives late, and a strobe nobody expected are each reported as a failure. The wrap-around case of R8 and the longest code are each run once in full.

// File: rtl/env_presc_pkg.sv
package env_presc_pkg;

   typedef enum logic [1:0] {
      PH_ATTACK  = 2'd0,
      PH_DECAY   = 2'd1,
      PH_RELEASE = 2'd2,
      PH_REL_ALT = 2'd3
   } phase_e;

   localparam int unsigned DEF_RATE_W = 4;
   localparam int unsigned DEF_LFSR_W = 15;

endpackage

// File: rtl/presc_rate_mux.sv
module presc_rate_mux
   import env_presc_pkg::*;
#(
   parameter int unsigned RATE_W = DEF_RATE_W
) (
   input  logic [RATE_W-1:0] atk_code,
   input  logic [RATE_W-1:0] dcy_code,
   input  logic [RATE_W-1:0] rel_code,
   input  logic [1:0]        sel,
   output logic [RATE_W-1:0] code
);

   phase_e ph;

   always_comb begin
      ph = phase_e'(sel);
      unique case (ph)
         PH_ATTACK: code = atk_code;
         PH_DECAY:  code = dcy_code;
         default:   code = rel_code;
      endcase
   end

endmodule

// File: rtl/presc_term_table.sv
module presc_term_table #(
   parameter int unsigned LFSR_W  = 15,
   parameter int unsigned RATE_W  = 4,
   parameter int unsigned TAP_A   = 14,
   parameter int unsigned TAP_B   = 13,
   parameter int unsigned N_CODES = 2**RATE_W,
   parameter int unsigned PERIODS [N_CODES] = '{8, 32, 63, 95, 149, 220, 267, 313,
                                                392, 977, 1954, 3126, 3907, 11720, 19532, 31251}
) (
   input  logic [RATE_W-1:0] code,
   output logic [LFSR_W-1:0] term
);

   localparam logic [LFSR_W-1:0] ONES   = {LFSR_W{1'b1}};
   localparam int unsigned       MAX_PER = (2**LFSR_W) - 1;

   typedef logic [LFSR_W-1:0][LFSR_W-1:0] lmap_t;

   // single shift of the register
   function automatic logic [LFSR_W-1:0] shift1(input logic [LFSR_W-1:0] s);
      return {s[LFSR_W-2:0], s[TAP_A] ^ s[TAP_B]};
   endfunction

   // apply a linear map (columns are images of unit vectors)
   function automatic logic [LFSR_W-1:0] map_apply(input lmap_t m, input logic [LFSR_W-1:0] v);
      logic [LFSR_W-1:0] r;
      r = '0;
      for (int i = 0; i < int'(LFSR_W); i++)
         if (v[i]) r ^= m[i];
      return r;
   endfunction

   function automatic lmap_t map_square(input lmap_t m);
      lmap_t n;
      for (int i = 0; i < int'(LFSR_W); i++)
         n[i] = map_apply(m, m[i]);
      return n;
   endfunction

   // state reached k shifts after all ones, by repeated squaring
   function automatic logic [LFSR_W-1:0] jump_from_ones(input int unsigned k);
      lmap_t             m;
      logic [LFSR_W-1:0] e;
      logic [LFSR_W-1:0] v;
      for (int i = 0; i < int'(LFSR_W); i++) begin
         e    = '0;
         e[i] = 1'b1;
         m[i] = shift1(e);
      end
      v = ONES;
      for (int j = 0; j <= int'(LFSR_W); j++) begin
         if (((k >> j) & 1) != 0) v = map_apply(m, v);
         m = map_square(m);
      end
      return v;
   endfunction

   logic [LFSR_W-1:0] tbl [N_CODES];

   generate
      if (N_CODES != 2**RATE_W) begin : g_bad_codes
         $error("period table size must match the rate code width");
      end
      for (genvar g = 0; g < int'(N_CODES); g++) begin : g_term
         if (PERIODS[g] < 2 || PERIODS[g] > MAX_PER) begin : g_bad_period
            $error("period out of range for the register length");
         end
         localparam logic [LFSR_W-1:0] TERM_PAT = jump_from_ones(PERIODS[g] - 1);
         assign tbl[g] = TERM_PAT;
      end
   endgenerate

   assign term = tbl[code];

endmodule

// File: rtl/presc_lfsr.sv
module presc_lfsr #(
   parameter int unsigned LFSR_W = 15,
   parameter int unsigned TAP_A  = 14,
   parameter int unsigned TAP_B  = 13
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reload,
   output logic [LFSR_W-1:0] state
);

   localparam logic [LFSR_W-1:0] ONES = {LFSR_W{1'b1}};

   generate
      if (LFSR_W < 4) begin : g_bad_w
         $error("register too short");
      end
      if (TAP_A >= LFSR_W || TAP_B >= LFSR_W || TAP_A == TAP_B) begin : g_bad_taps
         $error("feedback taps must be distinct and inside the register");
      end
   endgenerate

   logic [LFSR_W-1:0] q;
   logic              fb;

   assign fb = q[TAP_A] ^ q[TAP_B];

   always_ff @(posedge clk) begin
      if (rst || reload) q <= ONES;
      else               q <= {q[LFSR_W-2:0], fb};
   end

   assign state = q;

   // R1: reset leaves all ones
   p_reset_ones_r1: assert property (@(posedge clk) rst |=> (state == ONES))
      else $error("register not all ones after reset");

   // R2: zero is never entered
   p_nonzero_r2: assert property (@(posedge clk) disable iff (rst) state != '0)
      else $error("register locked at zero");

endmodule

// File: rtl/env_rate_prescaler.sv
module env_rate_prescaler
   import env_presc_pkg::*;
#(
   parameter int unsigned LFSR_W  = DEF_LFSR_W,
   parameter int unsigned RATE_W  = DEF_RATE_W,
   parameter int unsigned TAP_A   = 14,
   parameter int unsigned TAP_B   = 13,
   parameter int unsigned N_CODES = 2**RATE_W,
   parameter int unsigned PERIODS [N_CODES] = '{8, 32, 63, 95, 149, 220, 267, 313,
                                                392, 977, 1954, 3126, 3907, 11720, 19532, 31251}
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [RATE_W-1:0] rate_atk,
   input  logic [RATE_W-1:0] rate_dcy,
   input  logic [RATE_W-1:0] rate_rel,
   input  logic [1:0]        phase_sel,
   output logic              step
);

   localparam logic [LFSR_W-1:0] ONES = {LFSR_W{1'b1}};

   logic [RATE_W-1:0] code;
   logic [LFSR_W-1:0] term;
   logic [LFSR_W-1:0] lfsr_state;
   logic              match;
   logic              step_q;

   presc_rate_mux #(.RATE_W(RATE_W)) u_mux (
      .atk_code (rate_atk),
      .dcy_code (rate_dcy),
      .rel_code (rate_rel),
      .sel      (phase_sel),
      .code     (code)
   );

   presc_term_table #(
      .LFSR_W  (LFSR_W),
      .RATE_W  (RATE_W),
      .TAP_A   (TAP_A),
      .TAP_B   (TAP_B),
      .N_CODES (N_CODES),
      .PERIODS (PERIODS)
   ) u_tbl (
      .code (code),
      .term (term)
   );

   presc_lfsr #(
      .LFSR_W (LFSR_W),
      .TAP_A  (TAP_A),
      .TAP_B  (TAP_B)
   ) u_lfsr (
      .clk    (clk),
      .rst    (rst),
      .reload (match),
      .state  (lfsr_state)
   );

   assign match = (lfsr_state == term);

   always_ff @(posedge clk) begin
      if (rst) step_q <= 1'b0;
      else     step_q <= match;
   end

   assign step = step_q;

   // R1: no strobe after a reset edge
   p_rst_quiet_r1: assert property (@(posedge clk) rst |=> !step)
      else $error("strobe during reset");

   // R6: strobe lasts one cycle
   p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst) step |=> !step)
      else $error("strobe longer than one cycle");

   // R7: every strobe coincides with a fresh all-ones register
   p_reload_r7: assert property (@(posedge clk) disable iff (rst) step |-> (lfsr_state == ONES))
      else $error("register not reloaded on step");

endmodule

// File: tb/sim_env_rate_prescaler.sv
module sim_env_rate_prescaler;

   logic       clk = 1'b0;
   logic       rst;
   logic [3:0] atk, dcy, rel;
   logic [1:0] sel;
   logic       step;

   always #4 clk = ~clk;

   env_rate_prescaler u0 (
      .clk       (clk),
      .rst       (rst),
      .rate_atk  (atk),
      .rate_dcy  (dcy),
      .rate_rel  (rel),
      .phase_sel (sel),
      .step      (step)
   );

   int    cyc = 0;
   int    errors = 0;
   int    checks = 0;
   int    expq[$];
   string tagq[$];
   int    e_cyc;
   string e_tag;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic push(input int at, input string tag);
      expq.push_back(at);
      tagq.push_back(tag);
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic check_quiet(input string tag);
      checks++;
      if (step !== 1'b0) begin
         errors++;
         $display("FAIL %s: step=%b expected 0 at cycle %0d", tag, step, cyc);
      end
   endtask

   // monitor: pairs strobes with the expected cycle numbers
   always @(negedge clk) begin
      if (step === 1'b1) begin
         checks++;
         if (expq.size() == 0) begin
            errors++;
            $display("FAIL R6: strobe at cycle %0d, expected none", cyc);
         end else begin
            e_cyc = expq.pop_front();
            e_tag = tagq.pop_front();
            if (e_cyc != cyc) begin
               errors++;
               $display("FAIL %s: strobe at cycle %0d, expected %0d", e_tag, cyc, e_cyc);
            end
         end
      end else if (expq.size() > 0 && cyc > expq[0]) begin
         checks++;
         errors++;
         e_cyc = expq.pop_front();
         e_tag = tagq.pop_front();
         $display("FAIL %s: no strobe by cycle %0d, expected at %0d", e_tag, cyc, e_cyc);
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run hung at cycle %0d, expected end", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   int b;

   initial begin
      rst = 1'b1; atk = 4'd0; dcy = 4'd1; rel = 4'd5; sel = 2'd0;
      repeat (3) @(negedge clk);
      check_quiet("R1");
      rst = 1'b0;
      b = cyc;
      // R1 first strobe, R3 code 0 period 8, R7 spacing
      push(b + 8, "R1");
      push(b + 16, "R3");
      push(b + 24, "R7");
      push(b + 32, "R3");
      wait_until(b + 32);
      b = b + 32;
      // R5 decay select, R4 code 1 = 32
      sel = 2'd1;
      push(b + 32, "R5");
      wait_until(b + 32);
      b = b + 32;
      // R5 release select with code 5 = 220; R9 attack change ignored
      sel = 2'd2;
      atk = 4'd7;
      push(b + 220, "R4");
      push(b + 440, "R9");
      wait_until(b + 120);
      dcy = 4'd0;
      wait_until(b + 440);
      b = b + 440;
      // R8 forward change mid-interval, no reload
      sel = 2'd0;
      atk = 4'd0;
      wait_until(b + 3);
      atk = 4'd2;
      push(b + 63, "R8");
      wait_until(b + 63);
      b = b + 63;
      // R8 change to an already passed terminal: wrap (R2)
      atk = 4'd9;
      wait_until(b + 100);
      atk = 4'd0;
      push(b + 32767 + 8, "R2");
      push(b + 32767 + 16, "R8");
      wait_until(b + 32767 + 16);
      b = b + 32767 + 16;
      // R5 select 3 uses release; R4 longest code 15 = 31251
      sel = 2'd3;
      rel = 4'd15;
      push(b + 31251, "R4");
      wait_until(b + 31251);
      b = b + 31251;
      // R1 reset in mid run
      rst = 1'b1;
      rel = 4'd0;
      @(negedge clk);
      check_quiet("R1");
      @(negedge clk);
      check_quiet("R1");
      rst = 1'b0;
      b = cyc;
      push(b + 8, "R1");
      wait_until(b + 8);
      @(negedge clk);
      @(negedge clk);
      checks++;
      if (expq.size() != 0) begin
         errors++;
         $display("FAIL R7: %0d strobes outstanding, expected 0", expq.size());
      end
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule